// File: doc/BRIEF.md
# Gate-Captured Cascaded Event Counter

This block counts rising edges of a measured signal that arrives without any timing relation to the system clock. The count is held in two cascaded halves. The low half advances on every detected edge, and the high half advances when the low half rolls over. A separate gate signal marks the measurement intervals. On each rising gate edge, both halves are latched together as one combined value.

The block also subtracts the previous latched value from the new one. The result is the number of measured events in the last gate interval. Dividing that number by the gate period to get a frequency is left to the consumer. A ready flag tells the consumer that a fresh result exists, and a one-cycle acknowledge clears it. If a new result arrives before the old one was taken, a sticky flag records the loss.

Both the measured signal and the gate are brought into the clock domain through flop chains before their edges are detected. A correct count therefore needs each high and each low phase of the measured signal to last at least two system clock cycles.

Top module: `gate_event_counter`

## Requirements
- R1: Each rising edge of `sigIn` adds one to the low half, provided its high and low phases each last at least two clock cycles. A level that is held does not count again. The low half is `LOW_W` bits wide and wraps to zero after its all-ones value.
- R2: The high half (`HIGH_W` bits) adds one only on the edge that wraps the low half, and it also wraps. The combined count therefore wraps to zero every 2^(LOW_W+HIGH_W) events.
- R3: Each rising edge of `gateIn` loads `capValue` with high × 2^LOW_W + low. `capValue` keeps its value until the next gate edge. The result appears on the third clock edge after the raw gate rise is first sampled.
- R4: A measured edge whose detection falls in the same cycle as the capture is included in that capture. This includes any carry it produces into the high half.
- R5: A capture sets `dataReady`. A cycle with `readAck` high and no capture clears it on the next edge. When a capture and `readAck` happen in the same cycle, `dataReady` ends up set.
- R6: On each capture, `deltaCount` becomes the new capture minus the previous one, modulo 2^(LOW_W+HIGH_W).
- R7: `overrun` is set by a capture that occurs while `dataReady` is set and `readAck` is low. Once set, it stays set until reset.
- R8: `deltaValid` stays low until the second capture after reset. After that it stays high.
- R9: After reset, `capValue`, `deltaCount`, `dataReady`, `overrun` and `deltaValid` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sigIn | input | 1 | Measured signal, asynchronous to `clk` |
| gateIn | input | 1 | Gate signal; a rising edge triggers a capture |
| readAck | input | 1 | One-cycle acknowledge that clears `dataReady` |
| capValue | output | LOW_W+HIGH_W | Most recent combined capture |
| deltaCount | output | LOW_W+HIGH_W | Events counted between the last two captures |
| dataReady | output | 1 | A new capture has not yet been acknowledged |
| overrun | output | 1 | Sticky flag: an unread capture was overwritten |
| deltaValid | output | 1 | At least two captures have occurred |

## Verification
The bench runs with narrow halves so that carries between halves and wraps of the full count happen often. Random bursts of pulses, including empty bursts, test the counting and the subtraction, including deltas that cross a wrap. A long held high level shows that a level does not count again. Directed cases put a measured edge in the same cycle as the gate edge, once in the middle of the low half and once exactly on its rollover, which separates coherent capture from torn capture. A further case places an acknowledge in the capture cycle, which separates capture-wins priority and the overrun rule from the opposite choices.

// File: rtl/gec_pkg.sv
package gec_pkg;

  // Strobes issued by the control to the datapath, one cycle wide each.
  typedef struct packed {
    logic countEvent;   // advance the cascaded counter by one
    logic captureNow;   // latch the cascade and update the difference
  } dpStrobe_t;

endpackage

// File: rtl/gec_edge_sync.sv
module gec_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic risePulse
);

  logic [STAGES-1:0] syncChain;
  logic              lastLevel;

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rstN) syncChain[0] <= 1'b0;
          else       syncChain[0] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rstN) syncChain[gi] <= 1'b0;
          else       syncChain[gi] <= syncChain[gi-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) lastLevel <= 1'b0;
    else       lastLevel <= syncChain[STAGES-1];
  end

  assign risePulse = syncChain[STAGES-1] & ~lastLevel;

endmodule

// File: rtl/gec_control.sv
module gec_control
  import gec_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      sigRise,
  input  logic      gateRise,
  input  logic      readAck,
  output dpStrobe_t strobes,
  output logic      dataReady,
  output logic      overrun,
  output logic      deltaValid
);

  logic seenCapture;

  always_comb begin
    strobes.countEvent = sigRise;
    strobes.captureNow = gateRise;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataReady   <= 1'b0;
      overrun     <= 1'b0;
      deltaValid  <= 1'b0;
      seenCapture <= 1'b0;
    end else begin
      if (gateRise)     dataReady <= 1'b1;
      else if (readAck) dataReady <= 1'b0;
      overrun     <= overrun | (gateRise & dataReady & ~readAck);
      seenCapture <= seenCapture | gateRise;
      deltaValid  <= deltaValid | (gateRise & seenCapture);
    end
  end

endmodule

// File: rtl/gec_datapath.sv
module gec_datapath
  import gec_pkg::*;
#(
  parameter int LOW_W  = 16,
  parameter int HIGH_W = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  dpStrobe_t               strobes,
  output logic [LOW_W+HIGH_W-1:0] capValue,
  output logic [LOW_W+HIGH_W-1:0] deltaCount
);

  localparam int CNT_W = LOW_W + HIGH_W;

  logic [LOW_W-1:0]  lowCnt,  lowNext;
  logic [HIGH_W-1:0] highCnt, highNext;
  logic              lowCarry;
  logic [CNT_W-1:0]  joinedNext;

  // Capture uses the next-state values so a coincident edge and its carry land in both halves together.
  always_comb begin
    lowCarry   = strobes.countEvent & (&lowCnt);
    lowNext    = strobes.countEvent ? lowCnt + 1'b1 : lowCnt;
    highNext   = lowCarry ? highCnt + 1'b1 : highCnt;
    joinedNext = {highNext, lowNext};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowCnt     <= '0;
      highCnt    <= '0;
      capValue   <= '0;
      deltaCount <= '0;
    end else begin
      lowCnt  <= lowNext;
      highCnt <= highNext;
      if (strobes.captureNow) begin
        capValue   <= joinedNext;
        deltaCount <= joinedNext - capValue;
      end
    end
  end

endmodule

// File: rtl/gate_event_counter.sv
module gate_event_counter
  import gec_pkg::*;
#(
  parameter int LOW_W       = 16,
  parameter int HIGH_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    sigIn,
  input  logic                    gateIn,
  input  logic                    readAck,
  output logic [LOW_W+HIGH_W-1:0] capValue,
  output logic [LOW_W+HIGH_W-1:0] deltaCount,
  output logic                    dataReady,
  output logic                    overrun,
  output logic                    deltaValid
);

  localparam int CNT_W = LOW_W + HIGH_W;

  logic      sigRise;
  logic      gateRise;
  logic      capPulse;
  dpStrobe_t strobes;

  gec_edge_sync #(.STAGES(SYNC_STAGES)) uSigSync (
    .clk(clk), .rstN(rstN), .asyncIn(sigIn), .risePulse(sigRise)
  );

  gec_edge_sync #(.STAGES(SYNC_STAGES)) uGateSync (
    .clk(clk), .rstN(rstN), .asyncIn(gateIn), .risePulse(gateRise)
  );

  gec_control uCtrl (
    .clk(clk), .rstN(rstN), .sigRise(sigRise), .gateRise(gateRise),
    .readAck(readAck), .strobes(strobes), .dataReady(dataReady),
    .overrun(overrun), .deltaValid(deltaValid)
  );

  gec_datapath #(.LOW_W(LOW_W), .HIGH_W(HIGH_W)) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .capValue(capValue), .deltaCount(deltaCount)
  );

  assign capPulse = strobes.captureNow;

endmodule

// File: rtl/gec_checker.sv
module gec_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             sigRise,
  input logic             capPulse,
  input logic             readAck,
  input logic [CNT_W-1:0] capValue,
  input logic [CNT_W-1:0] deltaCount,
  input logic             dataReady,
  input logic             overrun,
  input logic             deltaValid
);

  // R1: a synchronised edge yields a single-cycle count pulse
  a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    sigRise |=> !sigRise);

  // R3: the capture holds between gate edges
  a_r3_cap_hold: assert property (@(posedge clk) disable iff (!rstN)
    !capPulse |=> $stable(capValue));

  // R5: a capture always leaves ready set
  a_r5_ready_set: assert property (@(posedge clk) disable iff (!rstN)
    capPulse |=> dataReady);

  // R5: an acknowledge with no capture clears ready
  a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rstN)
    (readAck && !capPulse) |=> !dataReady);

  // R6: the difference tracks consecutive captures
  a_r6_delta_diff: assert property (@(posedge clk) disable iff (!rstN)
    capPulse |=> deltaCount == capValue - $past(capValue));

  // R7: overrun is sticky
  a_r7_overrun_sticky: assert property (@(posedge clk) disable iff (!rstN)
    overrun |=> overrun);

  // R8: validity never drops once gained
  a_r8_valid_sticky: assert property (@(posedge clk) disable iff (!rstN)
    deltaValid |=> deltaValid);

endmodule

bind gate_event_counter gec_checker #(.CNT_W(CNT_W)) uChk (
  .clk(clk), .rstN(rstN), .sigRise(sigRise), .capPulse(capPulse),
  .readAck(readAck), .capValue(capValue), .deltaCount(deltaCount),
  .dataReady(dataReady), .overrun(overrun), .deltaValid(deltaValid)
);

// File: tb/tb_gate_event_counter.sv
module tb_gate_event_counter;

  localparam int LW = 4;
  localparam int HW = 4;
  localparam int CW = LW + HW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sigIn = 1'b0;
  logic gateIn = 1'b0;
  logic readAck = 1'b0;
  logic [CW-1:0] capValue, deltaCount;
  logic dataReady, overrun, deltaValid;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  logic [CW-1:0] mCount = '0;
  logic [CW-1:0] mCap = '0;
  logic [CW-1:0] mPrev = '0;
  bit mReady = 0, mOvr = 0;
  int mCaps = 0;

  always #2 clk = ~clk;  // 250 MHz

  gate_event_counter #(.LOW_W(LW), .HIGH_W(HW), .SYNC_STAGES(2)) dut (
    .clk(clk), .rstN(rstN), .sigIn(sigIn), .gateIn(gateIn), .readAck(readAck),
    .capValue(capValue), .deltaCount(deltaCount), .dataReady(dataReady),
    .overrun(overrun), .deltaValid(deltaValid)
  );

  function automatic logic [CW-1:0] expDelta(logic [CW-1:0] a, logic [CW-1:0] b);
    return a - b;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic waitNeg(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulses(int n);
    for (int i = 0; i < n; i++) begin
      sigIn = 1'b1; waitNeg(2);
      sigIn = 1'b0; waitNeg(2);
    end
    mCount += CW'(n);
  endtask

  task automatic modelCapture(bit ackSame);
    if (mReady && !ackSame) mOvr = 1;
    mReady = 1;
    mPrev = mCap;
    mCap = mCount;
    mCaps++;
  endtask

  task automatic checkAll(string tag);
    chk({tag, " R3 capValue"}, capValue, mCap);
    chk({tag, " R5 dataReady"}, dataReady, mReady);
    chk({tag, " R7 overrun"}, overrun, mOvr);
    chk({tag, " R8 deltaValid"}, deltaValid, mCaps >= 2);
    if (mCaps >= 2) chk({tag, " R6 deltaCount"}, deltaCount, expDelta(mCap, mPrev));
  endtask

  task automatic gateCapture();
    gateIn = 1'b1; waitNeg(4);
    modelCapture(0);
    gateIn = 1'b0; waitNeg(3);
  endtask

  task automatic ackRead();
    readAck = 1'b1; waitNeg(1);
    readAck = 1'b0;
    mReady = 0;
    chk("R5 ack clears ready", dataReady, 0);
  endtask

  initial begin
    void'($urandom(32'h1C0DE));
    waitNeg(3);
    chk("R9 capValue reset", capValue, 0);
    chk("R9 deltaCount reset", deltaCount, 0);
    chk("R9 dataReady reset", dataReady, 0);
    chk("R9 overrun reset", overrun, 0);
    chk("R9 deltaValid reset", deltaValid, 0);
    rstN = 1'b1;
    waitNeg(2);

    // R1: basic count, first capture; R8 delta not yet valid
    pulses(5);
    gateCapture();
    checkAll("first");
    ackRead();

    // R1: a long high level counts only once
    sigIn = 1'b1; waitNeg(12); sigIn = 1'b0; waitNeg(3);
    mCount += 1;
    gateCapture();
    checkAll("R1 held level");
    chk("R1 held level delta", deltaCount, 1);
    ackRead();

    // R4: coincident edge mid low half (low currently 6)
    sigIn = 1'b1; gateIn = 1'b1; mCount += 1; waitNeg(4);
    modelCapture(0);
    sigIn = 1'b0; gateIn = 1'b0; waitNeg(3);
    checkAll("R4 coincident");
    ackRead();

    // R4: coincident edge on low rollover with carry into high
    pulses(int'((2 ** LW - 1) - (mCount % (2 ** LW))));
    sigIn = 1'b1; gateIn = 1'b1; mCount += 1; waitNeg(4);
    modelCapture(0);
    sigIn = 1'b0; gateIn = 1'b0; waitNeg(3);
    checkAll("R4 carry coincident");
    chk("R2 carry low half zero", capValue % (2 ** LW), 0);

    // R5/R7: acknowledge in the capture cycle; capture wins, no overrun
    pulses(3);
    gateIn = 1'b1; waitNeg(2);
    readAck = 1'b1; waitNeg(1);
    readAck = 1'b0;
    modelCapture(1);
    waitNeg(1);
    gateIn = 1'b0; waitNeg(3);
    checkAll("R5 ack with capture");
    ackRead();

    // Random bursts, with wraps of the full count (R2/R6) and overruns (R7)
    for (int it = 0; it < 60; it++) begin
      pulses($urandom_range(0, 40));
      gateCapture();
      checkAll("random");
      if ($urandom_range(0, 2) != 0) ackRead();
    end
    chk("R7 overrun seen in random run", overrun, 1);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired: actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

endmodule